// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends asynchronous serial characters on a single line that idles high. Software writes a character into a one-entry holding register. When the shift stage is empty, the character moves into it on the next cycle. At that moment a one-cycle buffer-free pulse tells the writer that it may supply the next character. The shift stage waits for the next overflow of a divide-by-DIV prescaler before it drives the start bit. The prescaler counts an external 16x tick. The start bit is followed by the data field, least significant bit first, and then one or two stop bits.

A five-way mode select sets the data field. The field can be eight plain bits, seven bits plus parity, nine plain bits, eight bits plus parity, or eight bits plus a wake-up bit taken from data bit 8. The bench checks each of these field shapes. The format inputs are sampled at the moment a character enters the shift stage. A character written while the previous one is still shifting goes out directly behind it, with no idle time beyond its stop bits. A separate pulse marks the end of each character.

Top module: `sertx_top`

## Requirements
- R1: A start bit begins only in the cycle after a prescaler overflow, and only while `run_en` is high and a character sits in the shift stage. With `run_en` low the line stays high. All bit boundaries therefore lie on one grid of DIV ticks.
- R2: After reset `txd` is 1 and both pulse outputs are 0. A frame is a 0 start bit, then the data field LSB first, then stop bits of value 1. Each bit lasts DIV ticks.
- R3: `two_stop` = 1 gives two stop bits and 0 gives one. The value is sampled when the character enters the shift stage.
- R4: If the shift stage is empty, a character written in cycle t enters it at the edge that ends cycle t+1. `buf_irq` is high for exactly that following cycle and once per character.
- R5: The holding register accepts a write while a frame is shifting. That character raises `buf_irq` only when the current frame's last stop bit ends.
- R6: `mode_sel` = 3'b100 sends 9 data bits `wr_data[8:0]`.
- R7: `mode_sel` = 3'b111 sends `wr_data[7:0]` and then a parity bit. With `odd_par` = 0 the parity bit equals the XOR of the 8 bits. With `odd_par` = 1 it is the inverse.
- R8: `mode_sel` = 3'b101 sends `wr_data[7:0]` and then a wake-up bit equal to `wr_data[8]`.
- R9: `mode_sel` = 3'b011 sends `wr_data[6:0]` and then a parity bit computed over those 7 bits under the same odd/even rule as R7.
- R10: `mode_sel` = 3'b001, and every code not listed above, sends 8 data bits `wr_data[7:0]`.
- R11: When the next character is already held as a frame ends, its start bit follows the last stop bit with no gap.
- R12: `frame_done` pulses for one cycle right after the last stop bit of every character. There is exactly one pulse per character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_x16 | input | 1 | Oversampling tick, one cycle wide |
| run_en | input | 1 | Permits frames to start |
| mode_sel | input | 3 | Data field format |
| odd_par | input | 1 | 1 selects odd parity, 0 even |
| two_stop | input | 1 | 1 selects two stop bits |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Character to send |
| txd | output | 1 | Serial line, idles high |
| buf_irq | output | 1 | Pulse when the holding register empties into the shift stage |
| frame_done | output | 1 | Pulse after the last stop bit |

## Verification
The bench builds the block with DIV = 4 instead of 16. It drives the tick on every second clock, so each bit lasts eight clocks. This shortening puts around a dozen frames within a short run. The short runtime lets the bench cover every field shape, both parity senses, both stop counts, a held-off start with `run_en` low, and a chain of back-to-back characters. For every frame the bench checks gap-free start timing and alignment to the prescaler grid.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int FIELD_W = 9;
    localparam int FRAME_W = FIELD_W + 3;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        SX_IDLE  = 2'd0,
        SX_ARMED = 2'd1,
        SX_SEND  = 2'd2
    } sx_state_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;  // bit 0 goes out first
        logic [LEN_W-1:0]   len;   // total bit count including start and stops
    } sx_frame_t;

    // Assemble a complete line image for one character.
    function automatic sx_frame_t sx_build(input logic [2:0] mode,
                                           input logic odd,
                                           input logic two,
                                           input logic [FIELD_W-1:0] d);
        logic [FIELD_W-1:0] fld;
        logic [LEN_W-1:0]   nbits;
        sx_frame_t          fr;
        case (mode)
            3'b100, 3'b101: begin
                fld   = d;
                nbits = LEN_W'(9);
            end
            3'b111: begin
                fld   = {odd ^ (^d[7:0]), d[7:0]};
                nbits = LEN_W'(9);
            end
            3'b011: begin
                fld   = {1'b1, odd ^ (^d[6:0]), d[6:0]};
                nbits = LEN_W'(8);
            end
            default: begin
                fld   = {1'b1, d[7:0]};
                nbits = LEN_W'(8);
            end
        endcase
        fr.bits = {2'b11, fld, 1'b0};
        fr.len  = LEN_W'(1) + nbits + (two ? LEN_W'(2) : LEN_W'(1));
        return fr;
    endfunction

endpackage

// File: rtl/sertx_presc.sv
module sertx_presc #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic ovf
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (tick)
            cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
    end

    assign ovf = tick && (cnt == LAST);
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    output logic         valid,
    output logic [W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            if (wr_en) begin
                valid <= 1'b1;
                data  <= wr_data;
            end else if (take) begin
                valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ovf,
    input  logic      run_en,
    input  logic      hold_valid,
    input  sx_frame_t next_frame,
    output logic      take,
    output logic      txd,
    output logic      irq,
    output logic      done
);
    sx_state_e          state;
    logic [FRAME_W-1:0] sh;
    logic [LEN_W-1:0]   left;
    logic               last_bit;

    assign last_bit = (state == SX_SEND) && ovf && (left == LEN_W'(1));
    assign take     = hold_valid && ((state == SX_IDLE) || last_bit);
    assign txd      = (state == SX_SEND) ? sh[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SX_IDLE;
            sh    <= '1;
            left  <= '0;
            irq   <= 1'b0;
            done  <= 1'b0;
        end else begin
            irq  <= 1'b0;
            done <= 1'b0;
            case (state)
                SX_IDLE: begin
                    if (take) begin
                        sh    <= next_frame.bits;
                        left  <= next_frame.len;
                        irq   <= 1'b1;
                        state <= SX_ARMED;
                    end
                end
                SX_ARMED: begin
                    if (ovf && run_en)
                        state <= SX_SEND;
                end
                SX_SEND: begin
                    if (last_bit) begin
                        done <= 1'b1;
                        if (take) begin
                            sh    <= next_frame.bits;
                            left  <= next_frame.len;
                            irq   <= 1'b1;
                            state <= run_en ? SX_SEND : SX_ARMED;
                        end else begin
                            state <= SX_IDLE;
                        end
                    end else if (ovf) begin
                        sh   <= {1'b1, sh[FRAME_W-1:1]};
                        left <= left - LEN_W'(1);
                    end
                end
                default: state <= SX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DIV = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_x16,
    input  logic                run_en,
    input  logic [2:0]          mode_sel,
    input  logic                odd_par,
    input  logic                two_stop,
    input  logic                wr_en,
    input  logic [FIELD_W-1:0]  wr_data,
    output logic                txd,
    output logic                buf_irq,
    output logic                frame_done
);
    logic               ovf;
    logic               take;
    logic               hold_valid;
    logic [FIELD_W-1:0] hold_data;
    sx_frame_t          next_frame;

    sertx_presc #(.DIV(DIV)) u_presc (
        .clk(clk), .rst(rst), .tick(tick_x16), .ovf(ovf)
    );

    sertx_hold #(.W(FIELD_W)) u_hold (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .take(take), .valid(hold_valid), .data(hold_data)
    );

    assign next_frame = sx_build(mode_sel, odd_par, two_stop, hold_data);

    sertx_shift u_shift (
        .clk(clk), .rst(rst), .ovf(ovf), .run_en(run_en),
        .hold_valid(hold_valid), .next_frame(next_frame), .take(take),
        .txd(txd), .irq(buf_irq), .done(frame_done)
    );
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
    input logic clk,
    input logic rst,
    input logic ovf,
    input logic run_en,
    input logic hold_valid,
    input logic txd,
    input logic buf_irq,
    input logic frame_done
);
    p_start_on_ovf_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(txd) |-> ($past(ovf) && $past(run_en)));

    p_line_steps_on_ovf_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(txd) |-> $past(ovf));

    p_irq_from_hold_r4: assert property (@(posedge clk) disable iff (rst)
        buf_irq |-> $past(hold_valid));

    p_irq_single_r4: assert property (@(posedge clk) disable iff (rst)
        buf_irq |=> !buf_irq);

    p_done_after_stop_r12: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> ($past(txd) && $past(ovf)));
endmodule

bind sertx_top sertx_chk u_chk (
    .clk(clk), .rst(rst), .ovf(ovf), .run_en(run_en),
    .hold_valid(hold_valid), .txd(txd), .buf_irq(buf_irq),
    .frame_done(frame_done)
);

// File: tb/sim_sertx_top.sv
`timescale 1ns/1ps
module sim_sertx_top;
    localparam int DIV    = 4;
    localparam int BITCYC = DIV * 2;

    typedef struct {
        logic [11:0] bits;
        int          len;
        bit          b2b;
        string       tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       run_en = 1'b0;
    logic [2:0] mode_sel = 3'b001;
    logic       odd_par = 1'b0;
    logic       two_stop = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       txd, buf_irq, frame_done;

    int vectors = 0, fails = 0, cyc = 0;
    int irq_cnt = 0, done_cnt = 0, written = 0;
    bit in_frame = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    sertx_top #(.DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .tick_x16(tick), .run_en(run_en),
        .mode_sel(mode_sel), .odd_par(odd_par), .two_stop(two_stop),
        .wr_en(wr_en), .wr_data(wr_data), .txd(txd),
        .buf_irq(buf_irq), .frame_done(frame_done)
    );

    always @(posedge clk) cyc <= cyc + 1;

    initial forever begin
        @(negedge clk);
        tick = ~tick;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (buf_irq) irq_cnt <= irq_cnt + 1;
            if (frame_done) done_cnt <= done_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic exp_t mk(input logic [2:0] m, input logic odd,
                                input logic two, input logic [8:0] d);
        exp_t e;
        logic [8:0] f;
        int n;
        case (m)
            3'b100: begin f = d; n = 9; e.tag = "R6"; end
            3'b111: begin f = {(^d[7:0]) ^ odd, d[7:0]}; n = 9; e.tag = "R7"; end
            3'b101: begin f = {d[8], d[7:0]}; n = 9; e.tag = "R8"; end
            3'b011: begin f = {1'b1, (^d[6:0]) ^ odd, d[6:0]}; n = 8; e.tag = "R9"; end
            default: begin f = {1'b1, d[7:0]}; n = 8; e.tag = "R10"; end
        endcase
        e.bits = {2'b11, f, 1'b0};
        e.len  = 1 + n + (two ? 2 : 1);
        e.b2b  = 0;
        return e;
    endfunction

    // Driver: set format, write, push expectation, wait until taken.
    task automatic send(input logic [2:0] m, input logic odd, input logic two,
                        input logic [8:0] d, input bit b2b, input bit idle);
        exp_t e;
        e = mk(m, odd, two, d);
        e.b2b = b2b;
        @(negedge clk);
        mode_sel = m; odd_par = odd; two_stop = two;
        wr_en = 1'b1; wr_data = d;
        q.push_back(e);
        written++;
        @(negedge clk);
        wr_en = 1'b0;
        chk(buf_irq == 1'b0, "R4", buf_irq, 0);
        @(negedge clk);
        if (idle) chk(buf_irq == 1'b1, "R4", buf_irq, 1);
        else      chk(buf_irq == 1'b0, "R5", buf_irq, 0);
        while (!buf_irq) @(negedge clk);
    endtask

    // Monitor: decode the line and compare against the queue.
    initial begin
        int prev_st, prev_len, first_st;
        bit have_prev;
        exp_t e;
        have_prev = 0;
        prev_st = 0; prev_len = 0; first_st = 0;
        @(negedge clk);
        while (rst) @(negedge clk);
        forever begin
            @(negedge clk);
            if (!txd) begin
                int st;
                in_frame = 1;
                st = cyc;
                if (q.size() == 0) begin
                    chk(0, "R1", 0, 1);
                    e = mk(3'b001, 0, 0, 9'h1FF);
                end else begin
                    e = q.pop_front();
                end
                if (have_prev) begin
                    chk(((st - first_st) % BITCYC) == 0, "R1", (st - first_st) % BITCYC, 0);
                    if (e.b2b)
                        chk(st == prev_st + prev_len * BITCYC, "R11", st, prev_st + prev_len * BITCYC);
                end else begin
                    first_st = st;
                end
                repeat (4) @(negedge clk);
                chk(txd == 1'b0, "R2", txd, 0);
                for (int i = 1; i < e.len; i++) begin
                    repeat (BITCYC) @(negedge clk);
                    if (i >= e.len - 2 && e.bits[i] == 1'b1 && (i > 9 || i == e.len - 1))
                        chk(txd == e.bits[i], "R3", txd, e.bits[i]);
                    else
                        chk(txd == e.bits[i], e.tag, txd, e.bits[i]);
                end
                have_prev = 1;
                prev_st = st;
                prev_len = e.len;
                in_frame = 0;
            end
        end
    end

    task automatic drain();
        @(negedge clk);
        while (q.size() != 0 || in_frame) @(negedge clk);
        repeat (2 * BITCYC) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R2", txd, 1);
        chk(buf_irq == 1'b0, "R2", buf_irq, 0);
        chk(frame_done == 1'b0, "R2", frame_done, 0);

        // Held off by run_en: loaded but line stays idle (R1).
        send(3'b001, 0, 0, 9'h05A, 0, 1);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!txd) chk(0, "R1", txd, 1);
        end
        chk(txd == 1'b1, "R1", txd, 1);
        run_en = 1'b1;
        drain();

        // Burst across all field shapes; later ones queue behind (R5, R11).
        send(3'b100, 0, 0, 9'h1A5, 0, 1);
        send(3'b111, 0, 0, 9'h037, 1, 0);
        send(3'b111, 1, 0, 9'h037, 1, 0);
        send(3'b101, 0, 0, 9'h1C3, 1, 0);
        send(3'b101, 0, 1, 9'h0C3, 1, 0);
        send(3'b011, 0, 0, 9'h055, 1, 0);
        send(3'b011, 1, 0, 9'h02B, 1, 0);
        send(3'b001, 0, 1, 9'h0F0, 1, 0);
        send(3'b010, 0, 0, 9'h13C, 1, 0);
        send(3'b100, 0, 1, 9'h0FF, 1, 0);
        drain();

        // Lone character after idle must stay on the prescaler grid (R1).
        send(3'b111, 1, 1, 9'h0A6, 0, 1);
        drain();

        chk(irq_cnt == written, "R4", irq_cnt, written);
        chk(done_cnt == written, "R12", done_cnt, written);
        chk(q.size() == 0, "R2", q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        vectors++;
        $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule